// File: doc/BRIEF.md
# SAR conversion sequencer

This block is the digital control for a 12-bit successive-approximation converter. A period counter walks a fixed cycle of 15 clock periods numbered 1 to 15. In the first three periods a track control holds the analog sample switch closed. In periods 4 to 15 a binary search runs, one bit per period, starting at the most significant bit. The block drives the trial word to an external DAC and samples a comparator decision at the end of each test period. The finished word is written to an output register on entry to the next period 1. A data-ready flag is raised for that period, and the word is presented on a 12-bit bus made of two byte lanes, each with its own enable.

A low level on the start input lets the sequencer run freely, one conversion after another. If start is inactive when period 1 is reached, the sequencer parks in period 2. There it keeps tracking and keeps data-ready high until start is applied again. Start passes through a two-flop synchronizer, and it is only looked at in period 1 and while parked.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A conversion cycle is exactly 15 clock periods. Period 15 is always followed by period 1, so in free-running mode data-ready rises every 15 clock cycles.
- R2: `track_o` is high in periods 1 to 3 and while parked, and low in periods 4 to 15. In free-running mode it is high for 3 cycles out of every 15.
- R3: The search presents trial word 12'h800 on `dac_o` in period 4. In each of periods 4 to 15 it decides one bit, from bit 11 down to bit 0: `cmp_i`=1 (input at or above the trial) keeps the bit and `cmp_i`=0 clears it. The final word equals the input code.
- R4: The output word changes only on entry to period 1, where it takes the result of the conversion that has just ended. At all other times it holds its value.
- R5: `rdy_o` is high for the single cycle of period 1 and low in periods 2 to 15. Once a result exists, it stays high for as long as the sequencer is parked.
- R6: With `start_n` held low, each new conversion starts right after period 15, with no idle cycles.
- R7: If the synchronized start is inactive in period 1, the sequencer stops in period 2. While stopped, `track_o` stays high and the output word is held.
- R8: While parked, a low on `start_n` lasting at least 2 clock cycles resumes the sequence at period 3. A start pulse that arrives during periods 3 to 15 is ignored and cannot prevent the next park.
- R9: With `oe_hi_n` low, bus bits 11:4 carry result bits 11:4. With `oe_lo_n` low, bus bits 3:0 carry result bits 3:0. A lane whose enable is high is high-impedance.
- R10: Asynchronous active-low reset clears the trial and output registers to 0, drops `rdy_o`, and leaves the sequencer parked in period 2 with `track_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start; low permanently gives free-running mode |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above the trial word |
| track_o | output | 1 | Track/hold control, 1 = track |
| dac_o | output | 12 | Trial word for the DAC |
| rdy_o | output | 1 | Data-ready flag |
| oe_hi_n | input | 1 | Active-low enable for bus bits 11:4 |
| oe_lo_n | input | 1 | Active-low enable for bus bits 3:0 |
| data_o | inout | 12 | Result bus; a disabled lane floats (tri-state) |

## Verification
The bound checker checks the following on every cycle:
- the period counter stays in range and wraps from period 15 to period 1;
- track falls only on entry to period 4;
- the first trial word appears in period 4;
- the result register changes only in period 1;
- data-ready is high only in period 1 or while parked;
- the sequencer holds in period 2 while it is parked without a start.

Only the bench's scenarios can show the rest:
- conversion accuracy, against a comparator model over extreme and alternating codes;
- the 15-cycle spacing and the 3-cycle track width of free-running mode;
- that a start pulse in mid-conversion is ignored;
- the behaviour of the byte lanes;
- recovery from a reset in mid-conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // width of a counter that holds period numbers 1..n
  function automatic int unsigned period_bits(int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic start_act
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = ~start_n;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], ~start_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign start_act = sync_q[STAGES-1];
endmodule

// File: rtl/sar_period_ctr.sv
module sar_period_ctr #(
  parameter int unsigned NPER = 15,
  localparam int unsigned PW = sar_seq_pkg::period_bits(NPER)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_act,
  output logic [PW-1:0] period,
  output logic          halted
);
  localparam logic [PW-1:0] P_ONE  = PW'(1);
  localparam logic [PW-1:0] P_TWO  = PW'(2);
  localparam logic [PW-1:0] P_LAST = PW'(NPER);

  logic [PW-1:0] per_q, per_d;
  logic          cont_q, cont_d;
  logic          adv;

  always_comb begin
    per_d  = per_q;
    cont_d = cont_q;
    adv    = 1'b1;
    if (per_q == P_ONE) cont_d = start_act;     // only period 1 decides run/park
    if (per_q == P_TWO) adv = cont_q | start_act;
    if (adv) per_d = (per_q == P_LAST) ? P_ONE : per_q + P_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= P_TWO;
      cont_q <= 1'b0;
    end else begin
      per_q  <= per_d;
      cont_q <= cont_d;
    end
  end

  assign period = per_q;
  assign halted = (per_q == P_TWO) & ~cont_q;
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned NPER  = 15,
  localparam int unsigned PW    = sar_seq_pkg::period_bits(NPER),
  localparam int unsigned FIRST = NPER - WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    period,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result,
  output logic             have
);
  localparam logic [PW-1:0] P_PRE  = PW'(FIRST - 1);
  localparam logic [PW-1:0] P_LAST = PW'(NPER);

  logic [WIDTH-1:0] sar_q, sar_d, res_q, res_d;
  logic             have_q, have_d;

  always_comb begin
    sar_d  = sar_q;
    res_d  = res_q;
    have_d = have_q;
    if (period == P_PRE) sar_d = {1'b1, {(WIDTH-1){1'b0}}};
    // decision on bit b during period NPER-b
    for (int b = 0; b < WIDTH; b++)
      if (period == PW'(NPER - b)) sar_d[b] = cmp_i;
    // next lower trial bit
    for (int b = 1; b < WIDTH; b++)
      if (period == PW'(NPER - b)) sar_d[b-1] = 1'b1;
    if (period == P_LAST) begin
      res_d  = sar_d;
      sar_d  = '0;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      res_q  <= '0;
      have_q <= 1'b0;
    end else begin
      sar_q  <= sar_d;
      res_q  <= res_d;
      have_q <= have_d;
    end
  end

  assign trial  = sar_q;
  assign result = res_q;
  assign have   = have_q;
endmodule

// File: rtl/sar_out_lanes.sv
module sar_out_lanes #(
  parameter int unsigned WIDTH   = 12,
  parameter int unsigned LO_BITS = 4
) (
  input  logic [WIDTH-1:0] result,
  input  logic             oe_hi_n,
  input  logic             oe_lo_n,
  inout  wire  [WIDTH-1:0] bus
);
  assign bus[WIDTH-1:LO_BITS] = oe_hi_n ? {(WIDTH-LO_BITS){1'bz}} : result[WIDTH-1:LO_BITS];
  assign bus[LO_BITS-1:0]     = oe_lo_n ? {LO_BITS{1'bz}}         : result[LO_BITS-1:0];
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int unsigned WIDTH   = 12,
  parameter int unsigned NPER    = 15,
  parameter int unsigned NTRACK  = 3,
  parameter int unsigned LO_BITS = 4,
  parameter int unsigned SYNC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             cmp_i,
  output logic             track_o,
  output logic [WIDTH-1:0] dac_o,
  output logic             rdy_o,
  input  logic             oe_hi_n,
  input  logic             oe_lo_n,
  inout  wire  [WIDTH-1:0] data_o
);
  localparam int unsigned PW = sar_seq_pkg::period_bits(NPER);
  localparam logic [PW-1:0] P_ONE = PW'(1);
  localparam logic [PW-1:0] P_TRK = PW'(NTRACK);

  logic             start_act;
  logic [PW-1:0]    period;
  logic             halted;
  logic [WIDTH-1:0] result;
  logic             have;

  sar_start_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .start_act(start_act));

  sar_period_ctr #(.NPER(NPER)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start_act(start_act),
    .period(period), .halted(halted));

  sar_search_reg #(.WIDTH(WIDTH), .NPER(NPER)) u_sar (
    .clk(clk), .rst_n(rst_n), .period(period), .cmp_i(cmp_i),
    .trial(dac_o), .result(result), .have(have));

  sar_out_lanes #(.WIDTH(WIDTH), .LO_BITS(LO_BITS)) u_lanes (
    .result(result), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .bus(data_o));

  assign track_o = (period <= P_TRK);
  assign rdy_o   = have & ((period == P_ONE) | halted);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned NPER   = 15,
  parameter int unsigned NTRACK = 3,
  localparam int unsigned PW    = sar_seq_pkg::period_bits(NPER),
  localparam int unsigned FIRST = NPER - WIDTH + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PW-1:0]    period,
  input logic             halted,
  input logic             start_act,
  input logic             track_o,
  input logic             rdy_o,
  input logic [WIDTH-1:0] dac_o,
  input logic [WIDTH-1:0] result
);
  // R1
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period >= PW'(1)) && (period <= PW'(NPER)));
  // R1
  per_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == PW'(NPER)) |=> (period == PW'(1)));
  // R2
  track_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track_o) |-> (period == PW'(NTRACK + 1)));
  // R3
  msb_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == PW'(FIRST)) |-> (dac_o == {1'b1, {(WIDTH-1){1'b0}}}));
  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (period == PW'(1)));
  // R5
  rdy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> ((period == PW'(1)) || halted));
  // R7
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start_act) |=> ((period == PW'(2)) && track_o));
endmodule

bind sar_seq_ctrl sar_seq_chk #(.WIDTH(WIDTH), .NPER(NPER), .NTRACK(NTRACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .period(period), .halted(halted),
  .start_act(start_act), .track_o(track_o), .rdy_o(rdy_o),
  .dac_o(dac_o), .result(result));

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n, start_n, oe_hi_n, oe_lo_n;
  logic [11:0] vin;
  logic        cmp, track, rdy;
  logic [11:0] dac;
  wire  [11:0] bus;

  int errs = 0, checks = 0;
  logic [11:0] expq[$];
  bit free_chk = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;                 // 250 MHz

  assign cmp = (vin >= dac);            // comparator model, R3 polarity

  sar_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmp_i(cmp),
    .track_o(track), .dac_o(dac), .rdy_o(rdy),
    .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .data_o(bus));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected results at each data-ready rise, times free-run windows
  logic rdy_prev = 1'b0;
  int   cyc = 0, trk = 0, rdc = 0;
  bit   win_ok = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (track) trk++;
    if (rdy)   rdc++;
    if (!rst_n) begin
      rdy_prev = 1'b0;
      win_ok = 1'b0;
    end else if (rdy && !rdy_prev) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4", "unexpected result", int'(bus), 0);
      end else begin
        logic [11:0] e;
        e = expq.pop_front();
        chk(bus == e, "R3", "conversion result", int'(bus), int'(e));
      end
      if (free_chk && win_ok) begin
        chk(cyc - 1 == 15, "R1", "cycles between results", cyc - 1, 15);
        chk(trk - 1 == 3, "R2", "track cycles per cycle", trk - 1, 3);
        chk(rdc - 1 == 1, "R5", "ready cycles per cycle", rdc - 1, 1);
      end
      win_ok = free_chk;
      cyc = 1;
      trk = track ? 1 : 0;
      rdc = 1;
    end
    rdy_prev = rdy;
  end

  task automatic convert_free(input logic [11:0] v);
    @(negedge clk);
    while (!track) @(negedge clk);
    vin = v;
    expq.push_back(v);
    while (track) @(negedge clk);
  endtask

  task automatic convert_single(input logic [11:0] v, input bit push);
    @(negedge clk);
    while (!track) @(negedge clk);
    vin = v;
    if (push) expq.push_back(v);
    start_n = 1'b0;
    repeat (3) @(negedge clk);
    start_n = 1'b1;
    while (track) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_n = 1'b1; oe_hi_n = 1'b0; oe_lo_n = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    chk(rdy == 1'b0, "R10", "ready in reset", int'(rdy), 0);
    chk(track == 1'b1, "R10", "track in reset", int'(track), 1);
    chk(bus == 12'h000, "R10", "result in reset", int'(bus), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(track == 1'b1 && rdy == 1'b0, "R7", "parked after reset",
        int'({track, rdy}), 2);

    // free-running mode
    start_n = 1'b0;
    free_chk = 1'b1;
    convert_free(12'h000);
    convert_free(12'hFFF);
    convert_free(12'h800);
    convert_free(12'h7FF);
    convert_free(12'hA5A);
    convert_free(12'h001);
    convert_free(12'h5A5);
    start_n = 1'b1;                       // released mid-conversion
    free_chk = 1'b0;
    repeat (30) @(negedge clk);
    chk(expq.size() == 0, "R6", "results pending", expq.size(), 0);
    repeat (40) @(negedge clk);
    chk(rdy == 1'b1, "R5", "ready held while parked", int'(rdy), 1);
    chk(track == 1'b1, "R7", "track held while parked", int'(track), 1);
    chk(bus == 12'h5A5, "R4", "result held while parked", int'(bus), 'h5A5);

    // single conversion with a start pulse in mid-conversion
    convert_single(12'hC3F, 1'b1);
    repeat (3) @(negedge clk);
    start_n = 1'b0;
    repeat (3) @(negedge clk);
    start_n = 1'b1;
    repeat (60) @(negedge clk);
    chk(expq.size() == 0, "R8", "resumed conversion result", expq.size(), 0);
    chk(rdy == 1'b1 && track == 1'b1, "R8", "late start ignored, parked",
        int'({rdy, track}), 3);

    // byte lanes
    oe_hi_n = 1'b0; oe_lo_n = 1'b1;
    @(negedge clk);
    chk(bus[11:4] == 8'hC3, "R9", "upper lane driven", int'(bus[11:4]), 'hC3);
    chk(bus[3:0] !== 4'hF, "R9", "lower lane floats", int'(bus[3:0]), 0);
    oe_hi_n = 1'b1; oe_lo_n = 1'b0;
    @(negedge clk);
    chk(bus[3:0] == 4'hF, "R9", "lower lane driven", int'(bus[3:0]), 'hF);
    chk(bus[11:4] !== 8'hC3, "R9", "upper lane floats", int'(bus[11:4]), 0);
    oe_hi_n = 1'b0; oe_lo_n = 1'b0;
    @(negedge clk);

    // reset in mid-conversion
    convert_single(12'h333, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b0 && bus == 12'h000, "R10", "mid-conversion reset",
        int'({rdy, bus}), 0);
    chk(track == 1'b1, "R10", "track after mid reset", int'(track), 1);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(rdy == 1'b0 && track == 1'b1, "R10", "parked after reset release",
        int'({rdy, track}), 1);
    chk(expq.size() == 0, "R4", "queue empty at end", expq.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule